// File: doc/BRIEF.md
# Byte-wide general-purpose I/O port

This block is an 8-bit general-purpose I/O port. Software sees three views through a small register interface: a direction register, an output data register and a pin-level view. Each bit is either an output, driven high or low from the data register, or an input. An input bit whose data bit is 1 turns on its pad pull-up. The pad output, output-enable and pull-up enable come straight from the two stored registers, so a register write changes the pad in the same edge that stores it.

The pin-level view is brought into the clock domain in two steps. The pad level is captured when the clock falls, which is the closing edge of a stage that is transparent while the clock is high. That held value is then loaded into the pin register at the next rising edge. An external transition therefore shows up between half a period and one and a half periods later, depending on where in the clock period it lands. A value that software writes to an output bit reaches the pin view one full period after the write edge.

Top module: `gpio_port`

## Requirements
- R1: While reset is high at a rising edge, the direction and data registers clear to 0. After that edge pad_oe, pad_out and pad_pu are all 0, and reads of the direction and data views return 0.
- R2: A write with address 1 stores wr_data in the direction register at that rising edge. A write with address 2 stores it in the data register. Reads at these addresses return the stored contents combinationally.
- R3: Writes with address 0 (pin view) or address 3 change no register and no pad output. A read of address 3 returns 0.
- R4: For each bit, pad_oe equals the direction bit (1 = output) and pad_out equals the data bit.
- R5: For each bit, pad_pu is 1 exactly when the direction bit is 0 and the data bit is 1.
- R6: A read of address 0 returns the pin register. If a pad changes while the clock is high, the new level is in the pin register after the next rising edge, so the latency is more than 0.5 and at most 1 clock period.
- R7: If a pad changes while the clock is low, the new level is in the pin register after the second rising edge, so the latency is more than 1 and at most 1.5 clock periods.
- R8: When a data register write drives an output pad, the pin view still shows the old level in the cycle right after the write edge. It shows the new level one full period after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, sampled at the rising edge |
| addr | input | 2 | View select: 0 pin, 1 direction, 2 data, 3 unused |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected view |
| pad_in | input | 8 | Pad levels as seen at the pins |
| pad_out | output | 8 | Pad output levels |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| pad_pu | output | 8 | Pad pull-up enables |

## Verification
External pad edges are applied at six phases of the clock period, three while the clock is high and three while it is low. The measured latency must fall in the shorter or the longer window that matches the phase, which shows whether the falling-edge capture and the rising-edge load sit on their correct edges. A written output pattern is read back through the pad loop both in the cycle right after the write and one cycle later, which separates a one-period path from a shorter or a longer one. A mixed direction and data pattern checks the per-bit pull-up and output-enable decoding, and writes to the pin and unused addresses must leave every view unchanged.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  // Register view selector; the encoding is visible to software.
  typedef enum logic [1:0] {
    GP_A_PIN  = 2'd0,
    GP_A_DIR  = 2'd1,
    GP_A_DATA = 2'd2,
    GP_A_NONE = 2'd3
  } gp_addr_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns/1ps
module gpio_ctrl_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] data_q
);
  logic wr_dir, wr_data_sel;

  always_comb begin
    wr_dir      = wr_en && (addr == GP_A_DIR);
    wr_data_sel = wr_en && (addr == GP_A_DATA);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      if (wr_dir)      dir_q  <= wr_data;
      if (wr_data_sel) data_q <= wr_data;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && data_q == '0)); // R1
  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == GP_A_DIR) |=> dir_q == $past(wr_data)); // R2
  AST_DATA_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == GP_A_DATA) |=> data_q == $past(wr_data)); // R2
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == GP_A_DIR) |=> $stable(dir_q)); // R3
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == GP_A_DATA) |=> $stable(data_q)); // R3
endmodule

// File: rtl/gpio_pad_ctl.sv
`timescale 1ns/1ps
module gpio_pad_ctl #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] data_q,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      pad_oe[i]  = dir_q[i];
      pad_out[i] = data_q[i];
      pad_pu[i]  = ~dir_q[i] & data_q[i];
    end
  end

  always_comb begin
    AST_PU_NOT_DRIVEN: assert ((pad_pu & pad_oe) == '0); // R5
  end
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_q
);
  // Stage one: the value a clock-high-transparent latch holds once it
  // closes, taken at the falling edge.
  logic [W-1:0] hold_q;

  always_ff @(negedge clk) begin
    if (rst) hold_q <= '0;
    else     hold_q <= pad_in;
  end

  // Stage two: load the held level at the rising edge.
  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= hold_q;
  end

  AST_HOLD_CAPTURE: assert property (@(negedge clk) disable iff (rst)
    !rst |=> hold_q == $past(pad_in)); // R7
  AST_PIN_FOLLOWS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $stable(hold_q) |=> pin_q == $past(hold_q)); // R6
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_pu
);
  logic [W-1:0] dir_q, data_q, pin_q;

  gpio_ctrl_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .dir_q(dir_q), .data_q(data_q)
  );

  gpio_pad_ctl #(.W(W)) u_pad (
    .dir_q(dir_q), .data_q(data_q),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .pad_in(pad_in), .pin_q(pin_q)
  );

  always_comb begin
    case (addr)
      GP_A_PIN:  rd_data = pin_q;
      GP_A_DIR:  rd_data = dir_q;
      GP_A_DATA: rd_data = data_q;
      default:   rd_data = '0;
    endcase
  end

  AST_OE_AFTER_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == GP_A_DIR) |=> pad_oe == $past(wr_data)); // R4
endmodule

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] pad_in;
  logic [W-1:0] pad_out, pad_oe, pad_pu;
  logic [W-1:0] ext = '0;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // Pad model: driven bits loop back, pulled-up inputs read 1.
  always_comb begin
    for (int i = 0; i < W; i++)
      pad_in[i] = pad_oe[i] ? pad_out[i] : (pad_pu[i] ? 1'b1 : ext[i]);
  end

  gpio_port #(.W(W)) u_gpio_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
  endtask

  function automatic logic [W-1:0] reg_peek(input logic [1:0] a);
    addr = a;
    return rd_data;
  endfunction

  task automatic read_at(input logic [1:0] a, output logic [W-1:0] v);
    addr = a;
    #0.1;
    v = rd_data;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_pu", pad_pu, 0);
    read_at(2'd1, v); chk("R1 dir read", v, 0);
    read_at(2'd2, v); chk("R1 data read", v, 0);
  endtask

  task automatic t_write_read;
    logic [W-1:0] v;
    reg_write(2'd1, 8'h3C);
    read_at(2'd1, v); chk("R2 dir readback", v, 8'h3C);
    reg_write(2'd2, 8'hA5);
    read_at(2'd2, v); chk("R2 data readback", v, 8'hA5);
    chk("R4 pad_oe", pad_oe, 8'h3C);
    chk("R4 pad_out", pad_out, 8'hA5);
    chk("R5 pad_pu", pad_pu, 8'hA5 & ~8'h3C);
  endtask

  task automatic t_ignored;
    logic [W-1:0] v;
    reg_write(2'd0, 8'hFF);
    reg_write(2'd3, 8'h00);
    read_at(2'd1, v); chk("R3 dir kept", v, 8'h3C);
    read_at(2'd2, v); chk("R3 data kept", v, 8'hA5);
    read_at(2'd3, v); chk("R3 unused read", v, 0);
    chk("R3 pad_out kept", pad_out, 8'hA5);
  endtask

  task automatic t_pullup_mix;
    logic [W-1:0] v;
    ext = 8'h00;
    reg_write(2'd1, 8'h0F);
    reg_write(2'd2, 8'hF6);
    chk("R5 pull-up on inputs only", pad_pu, 8'hF0);
    chk("R4 oe mixed", pad_oe, 8'h0F);
    repeat (2) @(posedge clk);
    #1;
    read_at(2'd0, v); chk("R5 pin view with pull-ups", v, 8'hF6);
  endtask

  // Phase p in ns after a rising edge; clock high for p < 5.
  task automatic t_latency(input int p, input int b);
    realtime t0, meas, exp_lat;
    int steps;
    logic lvl;
    reg_write(2'd1, 8'h00);
    reg_write(2'd2, 8'h00);
    repeat (3) @(posedge clk);
    addr = 2'd0;
    lvl = ~rd_data[b];
    @(posedge clk);
    #(p);
    ext[b] = lvl;
    t0 = $realtime;
    #0.25;
    steps = 0;
    while (rd_data[b] !== lvl && steps < 60) begin
      #0.5;
      steps++;
    end
    meas = $realtime - t0;
    exp_lat = ((p < 5) ? (10.0 - p) : (20.0 - p)) + 0.25;
    if (p < 5)
      chk($sformatf("R6 latency phase %0d (ps)", p), int'(meas * 1000), int'(exp_lat * 1000));
    else
      chk($sformatf("R7 latency phase %0d (ps)", p), int'(meas * 1000), int'(exp_lat * 1000));
  endtask

  task automatic t_loopback;
    logic [W-1:0] v;
    reg_write(2'd1, 8'hFF);
    reg_write(2'd2, 8'h00);
    repeat (3) @(posedge clk);
    reg_write(2'd2, 8'h5A);
    read_at(2'd0, v); chk("R8 old value right after write", v, 8'h00);
    @(posedge clk);
    #1;
    read_at(2'd0, v); chk("R8 new value one period later", v, 8'h5A);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_ignored();
    t_pullup_mix();
    t_latency(1, 0);
    t_latency(2, 3);
    t_latency(4, 7);
    t_latency(6, 1);
    t_latency(7, 4);
    t_latency(9, 6);
    t_loopback();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule